// File: doc/BRIEF.md
# Power Domain Request Controller

This block turns per-domain software power requests into power enables for six domains: RF core, serial, peripheral, system bus, memory subsystem and CPU. Several domains do not simply follow their own request bit. The bus can be held up by the RF core or by a running CPU. The memory subsystem is tied to the bus or to the CPU. The RF core is only released in deep sleep, or when it reports idle if it is configured that way. The CPU drops only once it reports idle.

Every enable passes through a settle counter that models switch ramp time. A domain counts as powered only after the counter has run out. A combinational status query takes a domain mask and returns one code when every selected domain is powered and settled, and another code otherwise. A separate flag reports that the RF core is powered, settled and has its clock running.

Top module: `pwr_domain_ctrl`

## Requirements
- R1: While reset is asserted, all enables and all powered flags are 0, the RF-ready flag is 0, and the query returns 0x2 for any non-empty mask.
- R2: The RF core enable (bit 0) is 1 when its request is 1. With its request at 0 and idle release not selected, it is 0 only while deep sleep is indicated.
- R3: With idle release selected and the RF request at 0, the RF core enable follows the inverse of the RF idle flag, whatever the deep-sleep input is.
- R4: The serial (bit 1) and peripheral (bit 2) enables equal their request bits.
- R5: The bus enable (bit 3) is 1 if its request is 1, if the RF core asks to keep the bus, or if the CPU domain is wanted on. Otherwise it is 0.
- R6: With its request at 1, the memory enable (bit 4) equals the bus-wanted condition of R5. With its request at 0, it equals the CPU-wanted condition of R7.
- R7: The CPU enable (bit 5) is 1 when its request is 1 or the CPU is not idle. It is 0 when the request is 0 and the CPU reports idle, which also releases bus and memory unless other terms hold them.
- R8: Each enable output changes one clock after the inputs that decide it.
- R9: A domain's powered flag rises SETTLE_CYCLES clocks after its enable rises. It falls in the same cycle that the enable falls. An enable that drops before the count ends restarts the full count when it comes back.
- R10: The query mask uses bit positions RF 0, serial 1, peripheral 2, bus 3, memory 4, CPU 5. The query returns 0x1 when every masked domain is powered (an empty mask included) and 0x2 otherwise, combinationally from the powered flags.
- R11: The RF-ready output is 1 exactly when the RF core is powered (R9) and the RF clock-enable input is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_on_req | input | 6 | Software on-request per domain (bit order as R10) |
| rf_bus_keep | input | 1 | RF core asks to keep the bus domain powered |
| rf_idle | input | 1 | RF core reports idle |
| rf_idle_release | input | 1 | Select release of the RF core on idle instead of on deep sleep |
| cpu_idle | input | 1 | CPU reports idle |
| deep_sleep | input | 1 | CPU is in deep sleep |
| rf_clk_on | input | 1 | RF core clock is running |
| query_mask | input | 6 | Domains selected for the status query |
| pwr_en | output | 6 | Power enable per domain |
| pwr_good | output | 6 | Domain powered and settled |
| query_status | output | 2 | 0x1 all masked domains on, 0x2 some off |
| rf_ready | output | 1 | RF core powered, settled and clocked |

## Verification
The bench builds the block with SETTLE_CYCLES set to 3. This is short enough that stimulus held for one to eight clocks often lets a counter expire, but just as often drops an enable mid-count. Both the restart path and the settled path of R9 are therefore exercised many times. Directed phases first set up each cross-domain rule on its own: RF release in both modes, bus held by the RF core, and memory following the CPU. Long random phases then mix all the inputs against the reference model.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int NUM_DOM = 6;

  localparam int D_RF   = 0;
  localparam int D_SER  = 1;
  localparam int D_PER  = 2;
  localparam int D_BUS  = 3;
  localparam int D_MEM  = 4;
  localparam int D_CPU  = 5;

  typedef enum logic [1:0] {
    QS_ALL_ON   = 2'b01,
    QS_SOME_OFF = 2'b10
  } qstat_e;
endpackage

// File: rtl/pdc_policy.sv
module pdc_policy
  import pdc_pkg::*;
(
  input  logic [NUM_DOM-1:0] req,
  input  logic               rf_bus_keep,
  input  logic               rf_idle,
  input  logic               rf_idle_release,
  input  logic               cpu_idle,
  input  logic               deep_sleep,
  output logic [NUM_DOM-1:0] want
);
  logic cpu_want;
  logic bus_want;
  logic rf_hold;

  always_comb begin
    cpu_want = req[D_CPU] | ~cpu_idle;
    bus_want = req[D_BUS] | rf_bus_keep | cpu_want;
    rf_hold  = rf_idle_release ? ~rf_idle : ~deep_sleep;

    want         = '0;
    want[D_RF]   = req[D_RF] | rf_hold;
    want[D_SER]  = req[D_SER];
    want[D_PER]  = req[D_PER];
    want[D_BUS]  = bus_want;
    want[D_MEM]  = req[D_MEM] ? bus_want : cpu_want;
    want[D_CPU]  = cpu_want;
  end

  // R4: peripheral-side domains do not depend on any cross-domain term
  always_comb begin
    a_r4_direct: assert (want[D_SER] == req[D_SER] && want[D_PER] == req[D_PER]);
  end
endmodule

// File: rtl/pdc_settle.sv
module pdc_settle #(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_next,
  output logic pwr_en,
  output logic pwr_good
);
  localparam int CW = (SETTLE_CYCLES > 0) ? $clog2(SETTLE_CYCLES + 1) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(SETTLE_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          en_q;
  logic          cnt_ce;

  always_comb begin
    cnt_ce = 1'b0;
    cnt_d  = cnt_q;
    if (!en_q) begin
      cnt_ce = (cnt_q != CNT_LOAD);
      cnt_d  = CNT_LOAD;
    end else if (cnt_q != '0) begin
      cnt_ce = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_LOAD;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_next;
  end

  assign pwr_en   = en_q;
  assign pwr_good = en_q & (cnt_q == '0);

  // R9: counter never exceeds its load value
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LOAD);

  generate
    if (SETTLE_CYCLES > 0) begin : g_chk
      // R9: the powered flag only appears on an enable that was already up
      a_r9_good_late: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_good) |-> $past(en_q));
    end
  endgenerate
endmodule

// File: rtl/pdc_query.sv
module pdc_query
  import pdc_pkg::*;
(
  input  logic [NUM_DOM-1:0] mask,
  input  logic [NUM_DOM-1:0] good,
  output logic [1:0]         status
);
  logic all_on;

  always_comb begin
    all_on = 1'b1;
    for (int i = 0; i < NUM_DOM; i++) begin
      if (mask[i] && !good[i]) all_on = 1'b0;
    end
    status = all_on ? QS_ALL_ON : QS_SOME_OFF;
  end

  // R10: exactly one of the two codes is presented
  always_comb begin
    a_r10_code: assert ($onehot(status));
  end
endmodule

// File: rtl/pwr_domain_ctrl.sv
module pwr_domain_ctrl
  import pdc_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DOM-1:0] sw_on_req,
  input  logic               rf_bus_keep,
  input  logic               rf_idle,
  input  logic               rf_idle_release,
  input  logic               cpu_idle,
  input  logic               deep_sleep,
  input  logic               rf_clk_on,
  input  logic [NUM_DOM-1:0] query_mask,
  output logic [NUM_DOM-1:0] pwr_en,
  output logic [NUM_DOM-1:0] pwr_good,
  output logic [1:0]         query_status,
  output logic               rf_ready
);
  logic [NUM_DOM-1:0] want;

  pdc_policy u_policy (
    .req             (sw_on_req),
    .rf_bus_keep     (rf_bus_keep),
    .rf_idle         (rf_idle),
    .rf_idle_release (rf_idle_release),
    .cpu_idle        (cpu_idle),
    .deep_sleep      (deep_sleep),
    .want            (want)
  );

  generate
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      pdc_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_next  (want[d]),
        .pwr_en   (pwr_en[d]),
        .pwr_good (pwr_good[d])
      );
    end
  endgenerate

  pdc_query u_query (
    .mask   (query_mask),
    .good   (pwr_good),
    .status (query_status)
  );

  assign rf_ready = pwr_good[D_RF] & rf_clk_on;

  // one clock after reset release the enables reflect sampled inputs
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_n) a_r1_reset_off: assert (pwr_en == '0 && pwr_good == '0);
  end

  a_r4_serial_follow: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> pwr_en[D_SER] == $past(sw_on_req[D_SER]));

  a_r5_bus_keep: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(rf_bus_keep) |-> pwr_en[D_BUS]);

  a_r7_cpu_busy: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(!cpu_idle) |-> pwr_en[D_CPU] && pwr_en[D_BUS]);

  a_r6_mem_released: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(!sw_on_req[D_MEM] && !sw_on_req[D_CPU] && cpu_idle)
      |-> !pwr_en[D_MEM]);

  a_r3_rf_idle_drop: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(rf_idle_release && rf_idle && !sw_on_req[D_RF])
      |-> !pwr_en[D_RF]);

  a_r11_ready_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    rf_ready |-> pwr_en[D_RF]);
endmodule

// File: tb/sim_pwr_domain_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_domain_ctrl;
  localparam int S = 3;
  localparam int N = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] req, qmask;
  logic keep, ridle, rrel, cidle, dsleep, rclk;
  logic [N-1:0] pwr_en, pwr_good;
  logic [1:0] qstat;
  logic rf_ready;

  always #4 clk = ~clk;

  pwr_domain_ctrl #(.SETTLE_CYCLES(S)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_on_req(req), .rf_bus_keep(keep),
    .rf_idle(ridle), .rf_idle_release(rrel), .cpu_idle(cidle),
    .deep_sleep(dsleep), .rf_clk_on(rclk), .query_mask(qmask),
    .pwr_en(pwr_en), .pwr_good(pwr_good), .query_status(qstat),
    .rf_ready(rf_ready)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit cmp_on = 0;
  bit m_en[N];
  int m_cnt[N];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bit m_want(int d);
    bit cpu_w, bus_w;
    cpu_w = req[5] || !cidle;
    bus_w = req[3] || keep || cpu_w;
    case (d)
      0: return req[0] || (rrel ? !ridle : !dsleep);
      1, 2: return req[d];
      3: return bus_w;
      4: return req[4] ? bus_w : cpu_w;
      default: return cpu_w;
    endcase
  endfunction

  function automatic string dom_tag(int d);
    case (d)
      0: return "R2 R3 R8";
      1, 2: return "R4 R8";
      3: return "R5 R8";
      4: return "R6 R8";
      default: return "R7 R8";
    endcase
  endfunction

  // reference model, advanced at every rising edge
  always @(posedge clk) begin
    bit w[N];
    if (!rst_n) begin
      for (int d = 0; d < N; d++) begin m_en[d] = 0; m_cnt[d] = S; end
    end else begin
      for (int d = 0; d < N; d++) w[d] = m_want(d);
      for (int d = 0; d < N; d++) begin
        if (!m_en[d]) m_cnt[d] = S;
        else if (m_cnt[d] > 0) m_cnt[d] = m_cnt[d] - 1;
        m_en[d] = w[d];
      end
    end
  end

  // compare away from the edge
  always @(posedge clk) begin
    bit all;
    bit g;
    cyc++;
    #2;
    if (cmp_on) begin
      all = 1;
      for (int d = 0; d < N; d++) begin
        g = m_en[d] && (m_cnt[d] == 0);
        chk(pwr_en[d] == m_en[d], dom_tag(d), pwr_en[d], m_en[d]);
        chk(pwr_good[d] == g, "R9", pwr_good[d], g);
        if (qmask[d] && !g) all = 0;
      end
      chk(qstat == (all ? 2'b01 : 2'b10), "R10", qstat, all ? 1 : 2);
      g = m_en[0] && (m_cnt[0] == 0) && rclk;
      chk(rf_ready == g, "R11", rf_ready, g);
    end
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  task automatic apply(input logic [N-1:0] r, input logic k, input logic ri,
                       input logic rr, input logic ci, input logic ds, input int hold);
    @(negedge clk);
    req = r; keep = k; ridle = ri; rrel = rr; cidle = ci; dsleep = ds;
    repeat (hold) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; req = '0; keep = 0; ridle = 0; rrel = 0; cidle = 1;
    dsleep = 0; rclk = 1; qmask = 6'h3F;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pwr_en == 0, "R1 enables", pwr_en, 0);
    chk(pwr_good == 0, "R1 powered", pwr_good, 0);
    chk(qstat == 2'b10, "R1 query", qstat, 2);
    chk(rf_ready == 0, "R1 rf_ready", rf_ready, 0);
    rst_n = 1;
    cmp_on = 1;

    apply(6'h3F, 0, 0, 0, 0, 0, 8);
    chk(qstat == 2'b01, "R10 all on", qstat, 1);
    chk(rf_ready == 1, "R11 ready", rf_ready, 1);
    qmask = 6'h00; #1;
    chk(qstat == 2'b01, "R10 empty mask", qstat, 1);
    qmask = 6'h3F;

    apply(6'h00, 0, 0, 0, 1, 0, 6);
    chk(pwr_en == 6'b000001, "R2 RF held awake", pwr_en, 6'b000001);
    apply(6'h00, 0, 0, 0, 1, 1, 3);
    chk(pwr_en == 6'b000000, "R2 RF off in deep sleep", pwr_en, 0);
    apply(6'h00, 0, 0, 1, 1, 1, 3);
    chk(pwr_en == 6'b000001, "R3 RF busy", pwr_en, 6'b000001);
    apply(6'h00, 0, 1, 1, 1, 0, 3);
    chk(pwr_en == 6'b000000, "R3 RF idle", pwr_en, 0);
    apply(6'h00, 1, 1, 1, 1, 0, 5);
    chk(pwr_en == 6'b001000, "R5 bus kept by RF", pwr_en, 6'b001000);
    qmask = 6'h08; #1;
    chk(qstat == 2'b01, "R10 bus only", qstat, 1);
    qmask = 6'h18; #1;
    chk(qstat == 2'b10, "R10 bus+mem", qstat, 2);
    qmask = 6'h3F;
    apply(6'h10, 1, 1, 1, 1, 0, 5);
    chk(pwr_en == 6'b011000, "R6 mem via bus", pwr_en, 6'b011000);
    apply(6'h00, 0, 0, 0, 0, 0, 5);
    chk(pwr_en == 6'b111001, "R7 CPU busy", pwr_en, 6'b111001);
    apply(6'h00, 0, 0, 0, 1, 0, 2);
    chk(pwr_en == 6'b000001, "R7 CPU idle release", pwr_en, 6'b000001);
    // R9 restart: on for two clocks, off one, on again
    apply(6'h02, 0, 0, 0, 1, 0, 2);
    apply(6'h00, 0, 0, 0, 1, 0, 1);
    apply(6'h02, 0, 0, 0, 1, 0, 2);
    chk(pwr_good[1] == 0, "R9 restart", pwr_good[1], 0);
    repeat (2) @(negedge clk);
    chk(pwr_good[1] == 1, "R9 settled", pwr_good[1], 1);

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      qmask = N'($urandom);
      rclk = 1'($urandom);
      apply(N'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 1 + ($urandom % 8));
    end

    cmp_on = 0;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule